// File: doc/BRIEF.md
# Host Link Wake/Interrupt SPI Handshake Controller

This block is the device side of a serial host link. The link uses a mode-3 SPI slave and two handshake wires. The host pulls `wake_n` low to ask for the link or to acknowledge it, and the device pulls `irq_n` low to say it is ready or to ask for service. A host-initiated exchange runs as follows: the host lowers `wake_n`, the device answers by lowering `irq_n`, the host runs SPI frames, and when the host raises `wake_n` again the device raises `irq_n`. A device-initiated exchange starts from the device: a byte waiting in the transmit queue makes the device lower `irq_n`. The host then acknowledges with `wake_n` low and clocks out one packet.

Each chip-select period starts with dummy 0xFF bytes, and the packet follows them. A byte of 0xFF from the host is treated as filler and is never forwarded. The host ends a packet by raising `wake_n`. If another packet is already queued at that moment, `irq_n` stays low. After `irq_n` has gone high, a pending window runs. If no request arrives before the window closes, the block raises a sleep request for a fixed guard time. During the guard time every request is ignored. All SPI and handshake pins are synchronised into the system clock before use.

Top module: `hostlink_hs`

## Requirements
- R1: Out of reset `irq_n` and `spi_miso` are high, and `sleep_req`, `rx_valid` and `tx_ready` are low.
- R2: Let `wake_n` go low while the block is idle or pending. On the third rising system-clock edge after that change, `irq_n` goes low. Once `wake_n` has been seen low and then goes high again with nothing queued, `irq_n` goes high on the third edge after that change.
- R3: While the block is idle or pending, `tx_valid` high makes `irq_n` go low on the next clock edge.
- R4: SPI frames use mode 3 and are 8 bits long, MSB first. `spi_mosi` is sampled on SCK rising edges and `spi_miso` changes after SCK falling edges. Each SCK phase must last at least four system clocks.
- R5: Every chip-select period opens with PAD_BYTES bytes of 0xFF. A packet byte is taken (`tx_ready` pulses) only after the host has acknowledged by holding `wake_n` low.
- R6: When no packet byte is available, the byte shifted out is 0xFF. While chip select is high, `spi_miso` is high.
- R7: A received byte other than 0xFF appears on `rx_data` with a one-cycle `rx_valid` pulse. A received 0xFF produces no pulse.
- R8: One `wake_n`-low session carries at most one packet, up to and including the byte marked `tx_last`. Later bytes in that session are 0xFF. If `tx_valid` is high when the host raises `wake_n`, `irq_n` stays low for the next packet.
- R9: After `irq_n` rises, SLEEP_CYCLES clock cycles pass without any request. Then `sleep_req` is high for exactly GUARD_CYCLES cycles, and the block returns to idle.
- R10: While `sleep_req` is high, `wake_n` and `tx_valid` have no effect on `irq_n`.
- R11: A request that arrives in the last pending cycle takes priority over sleep entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 8 | Head byte of the transmit packet queue |
| tx_valid | input | 1 | Queue holds a byte |
| tx_last | input | 1 | Head byte ends its packet |
| tx_ready | output | 1 | Head byte taken this cycle |
| rx_data | output | 8 | Last non-dummy byte received |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| spi_sck | input | 1 | SPI clock, idles high |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| wake_n | input | 1 | Host request/acknowledge, active low |
| irq_n | output | 1 | Device ready/request, active low |
| sleep_req | output | 1 | Sleep entry request (guard window) |

## Verification
Two pairs of events can land on the same clock edge, and each pair is provoked on purpose.

The first pair is a host request and the sleep timeout. The bench drops `wake_n` at a sweep of offsets around the end of the pending window, so one offset lands exactly on the last pending cycle. The second pair is the host's release of `wake_n` and a new packet entering the queue. The bench pushes the packet at the same edge on which the release becomes visible.

A behavioural model in the bench predicts `irq_n` and `sleep_req` on every clock. Any divergence shows at once whether the request won or the sleep entry won.

// File: rtl/hostlink_hs.sv
module hostlink_hs #(
  parameter int PAD_BYTES    = 1,
  parameter int SLEEP_CYCLES = 200000,
  parameter int GUARD_CYCLES = 600000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  input  logic       tx_last,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  input  logic       wake_n,
  output logic       irq_n,
  output logic       sleep_req
);
  localparam int TMAX = (SLEEP_CYCLES > GUARD_CYCLES) ? SLEEP_CYCLES : GUARD_CYCLES;
  localparam int CW = $clog2(TMAX + 1);
  localparam int PW = $clog2(PAD_BYTES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ACTIVE, ST_PEND, ST_SLEEP} st_t;

  st_t st;
  logic seen;
  logic [CW-1:0] tmr;

  logic [1:0] wk_sy, ck_sy, cs_sy, mo_sy;
  logic ck_q, cs_q;
  wire wk_s = wk_sy[1];
  wire mo_s = mo_sy[1];
  wire sel = ~cs_sy[1];
  wire sel_start = sel & cs_q;
  wire sck_rise = ck_sy[1] & ~ck_q;
  wire sck_fall = ~ck_sy[1] & ck_q;
  wire want = ~wk_s | tx_valid;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wk_sy <= 2'b11; ck_sy <= 2'b11; cs_sy <= 2'b11; mo_sy <= 2'b11;
      ck_q <= 1'b1; cs_q <= 1'b1;
    end else begin
      wk_sy <= {wk_sy[0], wake_n};
      ck_sy <= {ck_sy[0], spi_sck};
      cs_sy <= {cs_sy[0], spi_cs_n};
      mo_sy <= {mo_sy[0], spi_mosi};
      ck_q <= ck_sy[1];
      cs_q <= cs_sy[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; seen <= 1'b0; tmr <= '0;
    end else begin
      case (st)
        ST_IDLE:
          if (want) begin st <= ST_ACTIVE; seen <= 1'b0; end
        ST_ACTIVE:
          if (!wk_s) seen <= 1'b1;
          else if (seen) begin
            seen <= 1'b0;
            if (!tx_valid) begin st <= ST_PEND; tmr <= '0; end
          end
        ST_PEND:
          if (want) begin st <= ST_ACTIVE; seen <= 1'b0; end
          else if (tmr == CW'(SLEEP_CYCLES - 1)) begin st <= ST_SLEEP; tmr <= '0; end
          else tmr <= tmr + 1'b1;
        default:
          if (tmr == CW'(GUARD_CYCLES - 1)) st <= ST_IDLE;
          else tmr <= tmr + 1'b1;
      endcase
    end

  assign irq_n = (st != ST_ACTIVE);
  assign sleep_req = (st == ST_SLEEP);

  logic [2:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh;
  logic [PW-1:0] pad_cnt;
  logic pkt_done, miso_q;

  wire fetch_ok = (st == ST_ACTIVE) && seen && tx_valid && !pkt_done && (pad_cnt == '0);
  wire byte_start = sel && sck_fall && (bit_cnt == 3'd0);
  assign tx_ready = byte_start && fetch_ok;
  wire [7:0] next_byte = tx_ready ? tx_data : 8'hFF;
  wire [7:0] rx_word = {rx_sh[6:0], mo_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0; rx_sh <= '0; tx_sh <= 8'hFF; pad_cnt <= '0;
      pkt_done <= 1'b0; miso_q <= 1'b1; rx_valid <= 1'b0; rx_data <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (tx_ready && tx_last) pkt_done <= 1'b1;
      else if (!seen) pkt_done <= 1'b0;
      if (!sel) begin
        bit_cnt <= '0;
        miso_q <= 1'b1;
      end else begin
        if (sel_start) pad_cnt <= PW'(PAD_BYTES);
        if (sck_fall) begin
          if (bit_cnt == 3'd0) begin
            miso_q <= next_byte[7];
            tx_sh <= {next_byte[6:0], 1'b1};
            if (pad_cnt != '0) pad_cnt <= pad_cnt - 1'b1;
          end else begin
            miso_q <= tx_sh[7];
            tx_sh <= {tx_sh[6:0], 1'b1};
          end
        end
        if (sck_rise) begin
          rx_sh <= rx_word;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == 3'd7 && rx_word != 8'hFF) begin
            rx_valid <= 1'b1;
            rx_data <= rx_word;
          end
        end
      end
    end

  assign spi_miso = miso_q;

  p_rx_not_dummy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_data != 8'hFF);
  p_rx_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_sleep_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_req) |-> $past(irq_n));
  p_sleep_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_req) |-> irq_n);
  p_ready_in_session_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !irq_n);
  p_idle_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sy[1] && cs_q) |-> spi_miso);
endmodule

// File: tb/hostlink_hs_test.sv
`timescale 1ns/1ps
module hostlink_hs_test;
  localparam int PADN = 1;
  localparam int SLP = 40;
  localparam int GRD = 60;

  logic clk = 0, rst_n = 0;
  logic [7:0] tx_data;
  logic tx_valid, tx_last, tx_ready;
  logic [7:0] rx_data;
  logic rx_valid;
  logic sck = 1, cs_n = 1, mosi = 1, miso;
  logic wake_n = 1, irq_n, sleep_req;

  always #2.5 clk = ~clk;

  hostlink_hs #(.PAD_BYTES(PADN), .SLEEP_CYCLES(SLP), .GUARD_CYCLES(GRD)) uut (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .spi_sck(sck),
    .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso), .wake_n(wake_n), .irq_n(irq_n),
    .sleep_req(sleep_req));

  int vectors = 0, errors = 0;
  logic [8:0] txq[$];
  logic [7:0] rxq[$];
  logic pop_pending = 0;

  assign tx_valid = txq.size() > 0;
  assign tx_data  = tx_valid ? txq[0][7:0] : 8'h00;
  assign tx_last  = tx_valid ? txq[0][8] : 1'b0;

  // Reference model: 0 idle, 1 session, 2 pending, 3 sleep guard
  int mode = 0, cnt = 0;
  bit acked = 0;
  logic w1 = 1, w2 = 1;
  always @(posedge clk) begin
    if (!rst_n) begin
      mode <= 0; cnt <= 0; acked <= 0; w1 <= 1; w2 <= 1;
    end else begin
      w1 <= wake_n; w2 <= w1;
      if (mode == 0) begin
        if (!w2 || tx_valid) begin mode <= 1; acked <= 0; end
      end else if (mode == 1) begin
        if (!w2) acked <= 1;
        else if (acked) begin
          acked <= 0;
          if (!tx_valid) begin mode <= 2; cnt <= 1; end
        end
      end else if (mode == 2) begin
        if (!w2 || tx_valid) begin mode <= 1; acked <= 0; end
        else if (cnt == SLP) begin mode <= 3; cnt <= 1; end
        else cnt <= cnt + 1;
      end else begin
        if (cnt == GRD) mode <= 0;
        else cnt <= cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (pop_pending) void'(txq.pop_front());
    pop_pending = tx_ready;
    if (rst_n) begin
      vectors++;
      if (irq_n !== (mode != 1)) begin
        errors++;
        $display("FAIL R2/R3/R8/R11 irq_n=%b expected %b at %0t", irq_n, mode != 1, $time);
      end
      vectors++;
      if (sleep_req !== (mode == 3)) begin
        errors++;
        $display("FAIL R9/R10 sleep_req=%b expected %b at %0t", sleep_req, mode == 3, $time);
      end
      if (rx_valid) rxq.push_back(rx_data);
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sck = 0; mosi = mo[i];
      clks(8);
      sck = 1; mi[i] = miso;
      clks(7);
    end
  endtask

  task automatic session(input int n, input logic [7:0] mo[8], output logic [7:0] mi[8]);
    @(negedge clk); cs_n = 0;
    clks(8);
    for (int k = 0; k < n; k++) xfer(mo[k], mi[k]);
    clks(8); cs_n = 1; mosi = 1;
    clks(8);
  endtask

  logic [7:0] mo[8], mi[8];

  initial begin
    for (int k = 0; k < 8; k++) mo[k] = 8'hFF;
    clks(3);
    chk("R1 irq_n", {7'd0, irq_n}, 8'd1);
    chk("R1 miso", {7'd0, miso}, 8'd1);
    chk("R1 sleep_req", {7'd0, sleep_req}, 8'd0);
    chk("R1 rx_valid", {7'd0, rx_valid}, 8'd0);
    chk("R1 tx_ready", {7'd0, tx_ready}, 8'd0);
    rst_n = 1;
    clks(5);

    // R2 R4 R6 R7: host-initiated write with a dummy byte in the middle
    wake_n = 0; clks(6);
    chk("R2 irq low", {7'd0, irq_n}, 8'd0);
    mo[0] = 8'h12; mo[1] = 8'hFF; mo[2] = 8'h34; mo[3] = 8'h80;
    session(4, mo, mi);
    for (int k = 0; k < 4; k++) chk("R6 idle miso byte", mi[k], 8'hFF);
    chk("R7 rx count", 8'(rxq.size()), 8'd3);
    if (rxq.size() == 3) begin
      chk("R7 rx0", rxq[0], 8'h12);
      chk("R7 rx1", rxq[1], 8'h34);
      chk("R4 rx msb", rxq[2], 8'h80);
    end
    rxq.delete();
    for (int k = 0; k < 8; k++) mo[k] = 8'hFF;
    wake_n = 1; clks(4);
    chk("R2 irq high", {7'd0, irq_n}, 8'd1);

    // R9 R10: sleep window, wake ignored during it
    clks(SLP + 5);
    chk("R9 sleep entered", {7'd0, sleep_req}, 8'd1);
    wake_n = 0; clks(10);
    chk("R10 wake ignored", {7'd0, irq_n}, 8'd1);
    txq.push_back(9'h0AA); clks(5);
    chk("R10 tx ignored", {7'd0, irq_n}, 8'd1);
    void'(txq.pop_front());
    wake_n = 1;
    clks(GRD + 5);
    chk("R9 back idle", {7'd0, sleep_req}, 8'd0);

    // R3 R5 R8: device-initiated, two queued packets
    txq.push_back(9'h0A1); txq.push_back(9'h0A2); txq.push_back(9'h1A3);
    txq.push_back(9'h0B1); txq.push_back(9'h1B2);
    clks(2);
    chk("R3 irq on queue", {7'd0, irq_n}, 8'd0);
    session(2, mo, mi);
    chk("R5 no take before ack", mi[0], 8'hFF);
    chk("R5 no take before ack b1", mi[1], 8'hFF);
    wake_n = 0; clks(6);
    session(5, mo, mi);
    chk("R5 pad", mi[0], 8'hFF);
    chk("R5 pkt A0", mi[1], 8'hA1);
    chk("R4 pkt A1", mi[2], 8'hA2);
    chk("R5 pkt A2", mi[3], 8'hA3);
    chk("R8 after last", mi[4], 8'hFF);
    chk("R7 host dummies dropped", 8'(rxq.size()), 8'd0);
    wake_n = 1; clks(6);
    chk("R8 irq held", {7'd0, irq_n}, 8'd0);
    wake_n = 0; clks(6);
    session(4, mo, mi);
    chk("R5 pad B", mi[0], 8'hFF);
    chk("R8 pkt B0", mi[1], 8'hB1);
    chk("R8 pkt B1", mi[2], 8'hB2);
    chk("R6 empty", mi[3], 8'hFF);
    wake_n = 1; clks(6);
    chk("R8 irq released", {7'd0, irq_n}, 8'd1);
    clks(SLP + GRD + 10);

    // R8 corner: packet arrives on the edge where the release is seen
    wake_n = 0; clks(8);
    @(negedge clk); wake_n = 1;
    clks(1); txq.push_back(9'h1C7);
    clks(6);
    wake_n = 0; clks(6);
    session(2, mo, mi);
    chk("R8 late packet", mi[1], 8'hC7);
    wake_n = 1;
    clks(SLP + GRD + 10);

    // R11: request swept around the last pending cycle
    for (int d = -3; d <= 3; d++) begin
      wake_n = 0; clks(8);
      @(negedge clk); wake_n = 1;
      clks(SLP - 1 + d);
      wake_n = 0; clks(10);
      wake_n = 1;
      clks(SLP + GRD + 20);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule